// File: doc/BRIEF.md
# Display PHY Power-Up Sequencer

This block takes a display PHY out of its powered-down state once the PHY's own registers have been written. It drives three active-high controls toward the PHY: a clock enable, a shutdown release and a reset release. On a start request it first holds all three low for one cycle. It then raises them one at a time in that fixed order, with a programmable wait after each step. A longer settle wait follows before the PHY status is examined.

After the settle wait the block samples a resynchronized copy of the PHY status word at a fixed interval. The poll ends successfully as soon as either the PLL lock flag or the clock-lane stop-state flag is seen. If neither flag appears within a bounded number of samples, the poll ends with a timeout. A power-down input returns everything to the idle state in one step.

All durations are cycle counts given as parameters, so they can be derived from the system clock frequency. The interface is plain control and status with no data stream. A start is a one-cycle level sampled on the clock edge, and there is no handshake at the edge of the block.

Top module: `phy_pwrup_seq`

## Requirements
- R1: During and directly after reset, every output (clock enable, shutdown release, reset release, ready, timeout, busy) is low.
- R2: A start accepted while not busy gives one cycle with all three controls low and busy high. That cycle is followed by STEP_CYC cycles with only the clock enable high.
- R3: After that, the clock enable and the shutdown release are both high for STEP_CYC cycles, and the reset release is still low.
- R4: Next, all three controls are high for SETTLE_CYC cycles before the first status sample is taken, and busy stays high for the whole sequence.
- R5: The status word passes through two synchronizer flops. The poll samples it in the first poll cycle and then every POLL_CYC cycles. A sample with bit 0 (PLL lock) or bit 2 (clock-lane stop state) set makes ready go high in the next cycle, with busy low and all controls held high.
- R6: Status bits other than bit 0 and bit 2 have no effect on the outcome of the poll.
- R7: If POLL_MAX samples all fail, timeout goes high in the cycle after the last sample, with ready low, busy low and the controls held high.
- R8: A start request while busy is ignored, and the running sequence continues unchanged.
- R9: A power-down request clears all three controls, ready, timeout and busy in the next cycle. It takes priority over a simultaneous start.
- R10: A start given after ready or timeout clears both flags and replays the sequence from R2, beginning with the all-low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the power-up sequence |
| pwrdn_i | input | 1 | Request to power the PHY down immediately |
| phy_stat_i | input | STAT_W | Asynchronous PHY status word; bit 0 is PLL lock, bit 2 is clock-lane stop state |
| clk_en_o | output | 1 | PHY clock enable |
| unshut_o | output | 1 | PHY shutdown release |
| unrst_o | output | 1 | PHY reset release |
| ready_o | output | 1 | Poll succeeded; PHY is up |
| timeout_o | output | 1 | Poll exhausted without a ready indication |
| busy_o | output | 1 | Sequence in progress |

## Verification
The hardest case to reach from the ports is a ready flag that arrives part-way through the poll. Here the result depends on how the two-flop synchronizer latency lines up with the sampling grid. The bench sweeps the cycle at which the status word changes across the whole sequence, from before the start to after the last sample. For every arrival cycle it computes the sample that first sees the change and the cycle in which ready or timeout should rise. The same sweep places stray start pulses and power-down requests at every phase of the sequence.

// File: rtl/phy_pwrup_pkg.sv
package phy_pwrup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_OFF    = 3'd1,
    ST_CLKEN  = 3'd2,
    ST_UNSHUT = 3'd3,
    ST_SETTLE = 3'd4,
    ST_POLL   = 3'd5,
    ST_DONE   = 3'd6,
    ST_FAIL   = 3'd7
  } seq_state_e;

  // Output bundle in the order {clk_en, unshut, unrst, ready, timeout, busy}
  typedef struct packed {
    logic clk_en;
    logic unshut;
    logic unrst;
    logic ready;
    logic timeout;
    logic busy;
  } seq_out_t;

  function automatic seq_out_t decode_outs(seq_state_e s);
    seq_out_t o;
    o = '0;
    case (s)
      ST_OFF:    o.busy = 1'b1;
      ST_CLKEN:  begin o.clk_en = 1'b1; o.busy = 1'b1; end
      ST_UNSHUT: begin o.clk_en = 1'b1; o.unshut = 1'b1; o.busy = 1'b1; end
      ST_SETTLE,
      ST_POLL:   begin o.clk_en = 1'b1; o.unshut = 1'b1; o.unrst = 1'b1; o.busy = 1'b1; end
      ST_DONE:   begin o.clk_en = 1'b1; o.unshut = 1'b1; o.unrst = 1'b1; o.ready = 1'b1; end
      ST_FAIL:   begin o.clk_en = 1'b1; o.unshut = 1'b1; o.unrst = 1'b1; o.timeout = 1'b1; end
      default:   o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pwrup_sync.sv
module pwrup_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= '0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= '0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R2
  tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(val_i));

  // R4
  tmr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
  import phy_pwrup_pkg::*;
#(
  parameter int STAT_W     = 4,
  parameter int LOCK_BIT   = 0,
  parameter int STOP_BIT   = 2,
  parameter int STEP_CYC   = 100,
  parameter int SETTLE_CYC = 100000,
  parameter int POLL_CYC   = 100,
  parameter int POLL_MAX   = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pwrdn_i,
  input  logic [STAT_W-1:0] phy_stat_i,
  output logic              clk_en_o,
  output logic              unshut_o,
  output logic              unrst_o,
  output logic              ready_o,
  output logic              timeout_o,
  output logic              busy_o
);

  localparam int TMAX_A = (STEP_CYC > POLL_CYC) ? STEP_CYC : POLL_CYC;
  localparam int TMAX   = (SETTLE_CYC > TMAX_A) ? SETTLE_CYC : TMAX_A;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int NW     = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;

  seq_state_e      st_q, st_d;
  seq_out_t        out_q;
  logic [STAT_W-1:0] stat_s;
  logic            stat_ok;
  logic            t_load, t_exp;
  logic [TW-1:0]   t_val;
  logic [NW-1:0]   tries_q;
  logic            tries_clr, tries_inc;

  pwrup_sync #(.W(STAT_W), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (phy_stat_i),
    .q_o   (stat_s)
  );

  pwrup_timer #(.W(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (t_load),
    .val_i     (t_val),
    .expired_o (t_exp)
  );

  assign stat_ok = stat_s[LOCK_BIT] | stat_s[STOP_BIT];

  always_comb begin
    st_d      = st_q;
    t_load    = 1'b0;
    t_val     = '0;
    tries_clr = 1'b0;
    tries_inc = 1'b0;
    if (pwrdn_i) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE, ST_DONE, ST_FAIL: begin
          if (start_i) st_d = ST_OFF;
        end
        ST_OFF: begin
          st_d   = ST_CLKEN;
          t_load = 1'b1;
          t_val  = TW'(STEP_CYC - 1);
        end
        ST_CLKEN: begin
          if (t_exp) begin
            st_d   = ST_UNSHUT;
            t_load = 1'b1;
            t_val  = TW'(STEP_CYC - 1);
          end
        end
        ST_UNSHUT: begin
          if (t_exp) begin
            st_d   = ST_SETTLE;
            t_load = 1'b1;
            t_val  = TW'(SETTLE_CYC - 1);
          end
        end
        ST_SETTLE: begin
          if (t_exp) begin
            st_d      = ST_POLL;
            t_load    = 1'b1;
            t_val     = '0;
            tries_clr = 1'b1;
          end
        end
        ST_POLL: begin
          if (t_exp) begin
            if (stat_ok) begin
              st_d = ST_DONE;
            end else if (tries_q == NW'(POLL_MAX - 1)) begin
              st_d = ST_FAIL;
            end else begin
              tries_inc = 1'b1;
              t_load    = 1'b1;
              t_val     = TW'(POLL_CYC - 1);
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      out_q   <= '0;
      tries_q <= '0;
    end else begin
      st_q  <= st_d;
      out_q <= decode_outs(st_d);
      if (tries_clr)      tries_q <= '0;
      else if (tries_inc) tries_q <= tries_q + 1'b1;
    end
  end

  assign clk_en_o  = out_q.clk_en;
  assign unshut_o  = out_q.unshut;
  assign unrst_o   = out_q.unrst;
  assign ready_o   = out_q.ready;
  assign timeout_o = out_q.timeout;
  assign busy_o    = out_q.busy;

  // R3
  unshut_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unshut_o) |-> clk_en_o && $past(clk_en_o));

  // R4
  unrst_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unrst_o) |-> $past(unshut_o) && $past(clk_en_o));

  // R5
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(busy_o) && unrst_o && !busy_o && !timeout_o);

  // R7
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q < NW'(POLL_MAX) || POLL_MAX >= (1 << NW));

  // R9
  pwrdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_i |=> !(clk_en_o || unshut_o || unrst_o || ready_o || timeout_o || busy_o));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && clk_en_o && start_i && !pwrdn_i) |=> clk_en_o);

endmodule

// File: tb/phy_pwrup_seq_bench.sv
module phy_pwrup_seq_bench;

  localparam int PERIOD = 10;
  localparam int S  = 3;
  localparam int T  = 10;
  localparam int P  = 4;
  localparam int MX = 5;
  localparam int PB = 2 * S + T + 1;
  localparam int NEVER = 1 << 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       pwrdn = 1'b0;
  logic [3:0] stat = 4'd0;
  logic       c_en, c_ush, c_urst, c_rdy, c_to, c_busy;
  int         n_chk = 0;
  int         n_bad = 0;

  always #(PERIOD / 2) clk = ~clk;

  phy_pwrup_seq #(
    .STAT_W(4), .LOCK_BIT(0), .STOP_BIT(2),
    .STEP_CYC(S), .SETTLE_CYC(T), .POLL_CYC(P), .POLL_MAX(MX)
  ) u_phy_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pwrdn_i(pwrdn),
    .phy_stat_i(stat),
    .clk_en_o(c_en), .unshut_o(c_ush), .unrst_o(c_urst),
    .ready_o(c_rdy), .timeout_o(c_to), .busy_o(c_busy)
  );

  function automatic logic [5:0] obs();
    return {c_en, c_ush, c_urst, c_rdy, c_to, c_busy};
  endfunction

  // Cycle after edge E0 at which the poll ends, given first visible cycle okm
  function automatic int end_cycle(int okm);
    for (int k = 0; k < MX; k++)
      if (PB + k * P >= okm) return PB + k * P + 1;
    return PB + (MX - 1) * P + 1;
  endfunction

  function automatic bit ends_ok(int okm);
    return (okm <= PB + (MX - 1) * P);
  endfunction

  function automatic logic [5:0] exp_vec(int m, int okm);
    int em;
    em = end_cycle(okm);
    if (m == 0)         return 6'b000001;
    if (m <= S)         return 6'b100001;
    if (m <= 2 * S)     return 6'b110001;
    if (m < em)         return 6'b111001;
    if (ends_ok(okm))   return 6'b111100;
    return 6'b111010;
  endfunction

  task automatic check(logic [5:0] act, logic [5:0] exp, string tag, int m);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, m, act, exp);
    end
  endtask

  task automatic run(int a, logic [3:0] pat, int stray, int pd);
    bit good;
    int okm, em, last;
    string tag;
    good = pat[0] | pat[2];
    okm  = !good ? NEVER : (a < 0 ? 0 : a + 2);
    em   = end_cycle(okm);
    last = (pd >= 0) ? pd + 2 : em + 2;
    stat = (a < 0) ? pat : 4'd0;
    repeat (3) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    for (int m = 0; m <= last; m++) begin
      if (pd >= 0 && m > pd)       tag = "R9";
      else if (m == 0)             tag = "R2 R10";
      else if (m <= S)             tag = "R2 R8";
      else if (m <= 2 * S)         tag = "R3 R8";
      else if (m <= 2 * S + T)     tag = "R4";
      else if (m < em)             tag = "R5";
      else if (good)               tag = "R5";
      else                         tag = "R6 R7";
      check(obs(), (pd >= 0 && m > pd) ? 6'b000000 : exp_vec(m, okm), tag, m);
      if (m == a) stat = pat;
      start = (m == stray);
      pwrdn = (m == pd);
      @(posedge clk);
      #1;
    end
    start = 1'b0;
    pwrdn = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    #1;
    check(obs(), 6'b000000, "R1", -1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    #1 check(obs(), 6'b000000, "R1", 0);

    // R9: power-down together with start from idle
    start = 1'b1; pwrdn = 1'b1;
    @(posedge clk);
    #1 start = 1'b0; pwrdn = 1'b0;
    check(obs(), 6'b000000, "R9", 0);

    // R5, R8, R10: lock or stop-state arriving at every cycle
    foreach (pat_l[i]) ;
    for (int pi = 0; pi < 3; pi++) begin
      logic [3:0] pat;
      pat = (pi == 0) ? 4'b0001 : (pi == 1) ? 4'b0100 : 4'b0101;
      for (int a = -1; a <= PB + MX * P + 2; a++)
        run(a, pat, 2 + ((a + 1) % 12), -1);
    end

    // R6, R7: only unrelated bits set
    for (int pi = 0; pi < 3; pi++) begin
      logic [3:0] pat;
      pat = (pi == 0) ? 4'b0010 : (pi == 1) ? 4'b1000 : 4'b1010;
      run(-1, pat, -1, -1);
      run(5, pat, 4, -1);
    end

    // R9: power-down at every phase, including after ready
    for (int pd = 0; pd <= PB + 2; pd++)
      run(-1, 4'b0001, -1, pd);
    // R9: power-down after a timeout
    run(-1, 4'b0000, -1, PB + (MX - 1) * P + 2);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  logic [0:0] pat_l;

endmodule